// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a behavioural, synthesizable model of a synchronous SRAM with flow-through reads, built so that a write can be followed by a read, or a read by a write, with no idle cycle between them. Every control input is sampled on the rising clock edge, and only on edges where the active-low clock enable is low. An access starts with a load command. It then runs as a single access or as a burst of up to four beats, and the burst order is either linear or interleaved.

Write data follows its address by one clock. The next command can be issued on the same edge that takes in that data. The block therefore keeps the access type and the address of the access in flight, and it commits a pending write on the following enabled edge. A read issued on that edge sees the merged result of the write.

The shared data bus of a real device appears here as three ports: `din`, `dout`, and a drive enable `dout_en`. The bus timing is fixed, so there is no valid/ready handshake. No back-pressure exists. The only way to stall the block is the clock enable, which freezes all state.

Top module: `fbsram_top`

## Requirements
- R1: While `rst_n` is low, and after its release until a read is loaded, `dout_en` is 0. Reset clears the in-flight access state. Array contents stay undefined.
- R2: On a rising edge with `clk_en_n` high, no state changes and no write is committed. An ongoing read keeps showing the same data with `dout_en` high.
- R3: A load happens on an enabled edge with `adv_ld` low and all chip selects active (`sel0_n`=0, `sel1`=1, `sel2_n`=0). The load latches `addr`. `wr_n`=1 selects a read and `wr_n`=0 selects a write.
- R4: A read is flow-through. After the load edge, `dout` holds the word at the latched address with no further register stage. `dout_en` is 1 exactly when `oe_n` is low, and `oe_n` acts without waiting for a clock.
- R5: During a write access, `dout_en` is 0 whatever the value of `oe_n`. `din` and `byte_wr_n` are captured on the next enabled edge, and that capture completes the write.
- R6: A new read, write or deselect can be issued on the edge that captures write data. A read of the same address on that edge returns the newly written bytes.
- R7: Byte lane i is `din[8i+7:8i]`, and it is written only when `byte_wr_n[i]` is 0. Lanes that are not selected keep their old contents.
- R8: An enabled edge with `adv_ld` low and any chip select inactive deselects the block, and `dout_en` is 0 from the next cycle on. A later `adv_ld`=1 edge leaves the block deselected.
- R9: An enabled edge with `adv_ld` high advances an active burst and ignores the chip selects, `wr_n` and `burst_ilv`. The access type latched at load holds for the whole burst.
- R10: With `burst_ilv`=0 at load, beat n uses the address whose low two bits are (start+n) mod 4. The upper bits stay fixed.
- R11: With `burst_ilv`=1 at load, beat n uses low bits start XOR n. The mode is latched at load.
- R12: The fourth advance of a burst wraps back to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load or deselect, 1 = advance burst |
| wr_n | input | 1 | Access type at load: 1 read, 0 write |
| byte_wr_n | input | NBYTES | Active-low per-lane write enables |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| din | input | NBYTES*BYTE_W | Write data, one cycle after address |
| dout | output | NBYTES*BYTE_W | Read data |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The bench fills every word of the array using chained back-to-back writes, each issued on the data edge of the write before it. It then reads every word back the same way. This pass separates a correct one-cycle data offset from an off-by-one address or data pairing. All four byte-enable patterns are written and then read at once on the commit edge, which shows whether the merge honours each lane. Burst sweeps cover every start offset in both orders, with foreign chip-select, `wr_n` and order values on the advance edges, so linear order, interleaved order and latched type or mode can each be told apart. Separate sequences hold the clock enable across a read and across a pending write, deselect with and without a pending write, and toggle `oe_n` between edges.

// File: rtl/fbsram_pkg.sv
package fbsram_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;
endpackage

// File: rtl/fbsram_ctrl.sv
module fbsram_ctrl
  import fbsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en_n,
  input  logic sel0_n,
  input  logic sel1,
  input  logic sel2_n,
  input  logic adv_ld,
  input  logic wr_n,
  output logic active_q,
  output acc_e acc_q,
  output logic load,
  output logic advance,
  output logic commit
);
  timeunit 1ns; timeprecision 100ps;

  logic step;
  logic chips_ok;
  logic desel;

  assign step     = ~clk_en_n;
  assign chips_ok = ~sel0_n & sel1 & ~sel2_n;
  assign load     = step & ~adv_ld & chips_ok;
  assign desel    = step & ~adv_ld & ~chips_ok;
  assign advance  = step & adv_ld & active_q;
  // write data for the access in flight is taken on this enabled edge
  assign commit   = step & active_q & (acc_q == ACC_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      acc_q    <= ACC_READ;
    end else if (load) begin
      active_q <= 1'b1;
      acc_q    <= wr_n ? ACC_READ : ACC_WRITE;
    end else if (desel) begin
      active_q <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(active_q) && $stable(acc_q)));

  p_type_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld) |=> ($stable(acc_q) && $stable(active_q)));
endmodule

// File: rtl/fbsram_burst_seq.sv
module fbsram_burst_seq #(
  parameter int ADDR_W = 6,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ilv_in,
  output logic [ADDR_W-1:0] addr_q
);
  timeunit 1ns; timeprecision 100ps;

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              ilv_q;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
      ilv_q  <= ilv_in;
    end else if (advance) begin
      cnt_q  <= cnt_q + BEAT_W'(1);
    end
  end

  always_comb begin
    if (ilv_q) low = base_q[BEAT_W-1:0] ^ cnt_q;
    else       low = base_q[BEAT_W-1:0] + cnt_q;
  end

  assign addr_q = {base_q[ADDR_W-1:BEAT_W], low};

  p_load_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(addr_in)));

  p_linear_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ilv_q) |=>
      ((addr_q[BEAT_W-1:0] == BEAT_W'($past(addr_q[BEAT_W-1:0]) + BEAT_W'(1))) &&
       (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W]))));

  p_upper_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ilv_q) |=> (addr_q[ADDR_W-1:ADDR_W-HI_W] == $past(addr_q[ADDR_W-1:ADDR_W-HI_W])));
endmodule

// File: rtl/fbsram_array.sv
module fbsram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [NBYTES-1:0]        wr_byte_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_byte_n[g]) lane_q[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
    end

    // flow-through: combinational read of the current word
    assign rd_data[g*BYTE_W +: BYTE_W] = lane_q[rd_addr];
  end
endmodule

// File: rtl/fbsram_top.sv
module fbsram_top
  import fbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     sel0_n,
  input  logic                     sel1,
  input  logic                     sel2_n,
  input  logic                     adv_ld,
  input  logic                     wr_n,
  input  logic [NBYTES-1:0]        byte_wr_n,
  input  logic                     burst_ilv,
  input  logic                     oe_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_en
);
  timeunit 1ns; timeprecision 100ps;

  localparam int DATA_W = NBYTES * BYTE_W;

  logic              active_q;
  acc_e              acc_q;
  logic              load;
  logic              advance;
  logic              commit;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_word;

  fbsram_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sel0_n   (sel0_n),
    .sel1     (sel1),
    .sel2_n   (sel2_n),
    .adv_ld   (adv_ld),
    .wr_n     (wr_n),
    .active_q (active_q),
    .acc_q    (acc_q),
    .load     (load),
    .advance  (advance),
    .commit   (commit)
  );

  fbsram_burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .addr_in (addr),
    .ilv_in  (burst_ilv),
    .addr_q  (cur_addr)
  );

  // the write commits at the pre-edge address; the read sees the post-edge address
  fbsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk       (clk),
    .wr_en     (commit),
    .wr_addr   (cur_addr),
    .wr_data   (din),
    .wr_byte_n (byte_wr_n),
    .rd_addr   (cur_addr),
    .rd_data   (rd_word)
  );

  assign dout    = rd_word;
  assign dout_en = active_q & (acc_q == ACC_READ) & ~oe_n;

  logic port_sel_ok;
  assign port_sel_ok = ~sel0_n & sel1 & ~sel2_n;

  p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && port_sel_ok && !wr_n) |=> !dout_en);

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && port_sel_ok && wr_n) |=> (dout_en == !oe_n));

  p_deselect_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !port_sel_ok) |=> !dout_en);
endmodule

// File: tb/fbsram_top_bench.sv
module fbsram_top_bench;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b1;
  logic        sel0_n = 1'b1;
  logic        sel1 = 1'b0;
  logic        sel2_n = 1'b1;
  logic        adv_ld = 1'b0;
  logic        wr_n = 1'b1;
  logic [1:0]  byte_wr_n = 2'b11;
  logic        burst_ilv = 1'b0;
  logic        oe_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        dout_en;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] model [64];

  fbsram_top u_fbsram_top (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .adv_ld(adv_ld), .wr_n(wr_n), .byte_wr_n(byte_wr_n),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_sel(input logic ok);
    sel0_n = ~ok; sel1 = ok; sel2_n = ~ok;
  endtask

  task automatic op_load(input logic [5:0] a, input logic w_n, input logic ilv);
    clk_en_n = 1'b0; adv_ld = 1'b0; set_sel(1'b1);
    wr_n = w_n; addr = a; burst_ilv = ilv;
    tick();
  endtask

  task automatic op_adv(input logic w_n, input logic ilv);
    clk_en_n = 1'b0; adv_ld = 1'b1; set_sel(1'b0);
    wr_n = w_n; burst_ilv = ilv; addr = 6'h3f;
    tick();
  endtask

  task automatic op_des();
    clk_en_n = 1'b0; adv_ld = 1'b0; sel0_n = 1'b0; sel1 = 1'b0; sel2_n = 1'b0;
    tick();
  endtask

  task automatic put(input int a, input logic [15:0] d, input logic [1:0] be_n);
    for (int b = 0; b < 2; b++)
      if (!be_n[b]) model[a][b*8 +: 8] = d[b*8 +: 8];
  endtask

  function automatic logic [15:0] fill(input int a);
    return 16'(a * 16'h0101) ^ 16'h5a3c;
  endfunction

  function automatic int beat(input int s, input int n, input int ilv);
    return 8 + (ilv != 0 ? (s ^ n) : ((s + n) % 4));
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state, load commands ignored while held
    @(negedge clk);
    clk_en_n = 1'b0; adv_ld = 1'b0; set_sel(1'b1); wr_n = 1'b1;
    tick(); tick();
    chk("R1 dout_en in reset", {15'b0, dout_en}, 16'h0);
    rst_n = 1'b1;
    op_des();
    chk("R1 dout_en after release", {15'b0, dout_en}, 16'h0);

    // R5 R6: fill array with chained back-to-back writes
    byte_wr_n = 2'b00;
    op_load(6'd0, 1'b0, 1'b0);
    chk("R5 write hiz", {15'b0, dout_en}, 16'h0);
    for (int a = 1; a < 64; a++) begin
      din = fill(a - 1);
      op_load(6'(a), 1'b0, 1'b0);
      put(a - 1, fill(a - 1), 2'b00);
      chk("R5 write hiz chain", {15'b0, dout_en}, 16'h0);
    end
    din = fill(63);
    op_des();
    put(63, fill(63), 2'b00);

    // R3 R4: read everything back, one load per cycle
    for (int a = 0; a < 64; a++) begin
      op_load(6'(a), 1'b1, 1'b0);
      chk("R3 R4 read data", dout, model[a]);
      chk("R4 drive on read", {15'b0, dout_en}, 16'h1);
    end

    // R7 R6: each byte-enable pattern, read issued on the commit edge
    for (int be = 0; be < 4; be++) begin
      byte_wr_n = 2'(be);
      op_load(6'd5, 1'b0, 1'b0);
      din = 16'h1234 ^ 16'(be * 16'h1111) ^ 16'hff00;
      op_load(6'd5, 1'b1, 1'b0);
      put(5, din, 2'(be));
      chk("R7 R6 merged read", dout, model[5]);
    end
    byte_wr_n = 2'b00;

    // R9 R10 R11 R12: burst sweeps, all starts, both orders
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int s = 0; s < 4; s++) begin
        op_load(6'(8 + s), 1'b0, ilv[0]);
        for (int n = 0; n < 3; n++) begin
          din = 16'hb000 | 16'(ilv << 8) | 16'(s << 4) | 16'(n);
          op_adv(1'b1, ~ilv[0]);
          put(beat(s, n, ilv), din, 2'b00);
          chk("R9 write burst stays hiz", {15'b0, dout_en}, 16'h0);
        end
        din = 16'hb000 | 16'(ilv << 8) | 16'(s << 4) | 16'd3;
        op_des();
        put(beat(s, 3, ilv), din, 2'b00);

        op_load(6'(8 + s), 1'b1, ilv[0]);
        for (int n = 0; n < 4; n++) begin
          chk(ilv != 0 ? "R11 interleaved beat" : "R10 linear beat", dout, model[beat(s, n, ilv)]);
          chk("R9 read burst drives", {15'b0, dout_en}, 16'h1);
          op_adv(1'b0, ~ilv[0]);
        end
        chk("R12 wrap to start", dout, model[beat(s, 0, ilv)]);
      end
    end

    // R2: clock enable high freezes a read
    op_load(6'd3, 1'b1, 1'b0);
    clk_en_n = 1'b1; addr = 6'd40; wr_n = 1'b0; adv_ld = 1'b0; set_sel(1'b1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 hold read data", dout, model[3]);
      chk("R2 hold drive", {15'b0, dout_en}, 16'h1);
    end
    // R2: clock enable high defers a pending write capture
    op_load(6'd20, 1'b0, 1'b0);
    clk_en_n = 1'b1; din = 16'hdead;
    tick();
    din = 16'h1234;
    op_load(6'd20, 1'b1, 1'b0);
    put(20, 16'h1234, 2'b00);
    chk("R2 deferred write", dout, 16'h1234);

    // R8: deselect, advance while idle, deselect completing a write
    op_load(6'd1, 1'b1, 1'b0);
    chk("R8 read before deselect", {15'b0, dout_en}, 16'h1);
    op_des();
    chk("R8 deselect hiz", {15'b0, dout_en}, 16'h0);
    op_adv(1'b1, 1'b0);
    chk("R8 advance while idle", {15'b0, dout_en}, 16'h0);
    op_load(6'd2, 1'b0, 1'b0);
    din = 16'h0f0f;
    op_des();
    put(2, 16'h0f0f, 2'b00);
    op_load(6'd2, 1'b1, 1'b0);
    chk("R8 write done by deselect edge", dout, 16'h0f0f);

    // R4: output enable acts between edges
    op_load(6'd4, 1'b1, 1'b0);
    oe_n = 1'b1; #1;
    chk("R4 oe high hiz", {15'b0, dout_en}, 16'h0);
    oe_n = 1'b0; #1;
    chk("R4 oe low drive", {15'b0, dout_en}, 16'h1);
    chk("R4 oe low data", dout, model[4]);

    // R1: reset mid-read drops drive at once
    rst_n = 1'b0; #1;
    chk("R1 async reset hiz", {15'b0, dout_en}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    op_des();
    chk("R1 idle after reset", {15'b0, dout_en}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule